// File: doc/BRIEF.md
# Rising-Step Event Counter with Alarm

This block takes a 3-bit unsigned sample on every rising clock edge and compares it with the sample taken on the edge before. When the new value is larger than the old one by two or more, an event is counted in a 3-bit counter. The counter stops at six. The alarm output goes high on the edge where the counter reaches six.

The counter and the alarm have one way back to zero apart from reset. The input must read zero on three edges in a row. This clear holds for as long as the input stays at zero. Because the stored sample is then zero, the first jump to 2 or more after the clear counts again. The block suits event monitors that watch a slowly changing quantity for sharp upward steps and must latch an alarm until the source goes quiet.

Top module: `step_event_counter`

## Requirements
- R1: While rst_ni is low, count_o is 0 and alarm_o is 0. The stored previous sample is 0, so the first sample after reset is compared against 0.
- R2: On an edge where the sample exceeds the stored previous sample by 2 or more (unsigned), count_o rises by exactly one, provided it is below 6.
- R3: A sample that equals the previous one, exceeds it by only 1, or is smaller than it leaves count_o unchanged. The subtraction never wraps.
- R4: The previous sample is reloaded on every edge, whether or not that edge counted. So after 1, 2, 4 the step from 2 to 4 counts.
- R5: count_o never exceeds 6. At 6, further qualifying jumps leave it at 6 until a clear occurs.
- R6: alarm_o is high exactly when count_o is 6. It rises on the same edge on which count_o becomes 6 and stays high until a clear.
- R7: On the edge where the input is 0 for the third consecutive edge, count_o and alarm_o both become 0. Two zeros followed by a nonzero sample do not clear.
- R8: Further consecutive zero samples after a clear hold count_o at 0 and alarm_o low. A following sample of 2 or more then counts as one event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 3 | Unsigned sample input |
| count_o | output | 3 | Number of qualifying upward jumps, saturating at 6 |
| alarm_o | output | 1 | High while the count is at its limit |

## Verification
The hardest state to reach is a saturated counter with an alarm that must survive near-miss clears. In that state, runs of exactly two zeros are followed by a large sample, and that sample also qualifies as a jump. The stimulus reaches it by repeating the pair 1, 3 until six events have been counted. It then injects zero pairs, and only afterwards the full three-zero run with extra trailing zeros. A long stretch of random samples, biased towards zero, then mixes short and long zero runs with jumps in every position. A behavioural model built on a sample history is compared with the outputs on every clock.

// File: rtl/step_event_pkg.sv
package step_event_pkg;
  parameter int unsigned DATA_W   = 3;
  parameter int unsigned CNT_W    = 3;
  parameter int unsigned STEP_MIN = 2;
  parameter int unsigned CNT_MAX  = 6;
  parameter int unsigned ZERO_RUN = 3;
endpackage

// File: rtl/step_detect.sv
module step_detect #(
  parameter int unsigned DATA_W   = 3,
  parameter int unsigned STEP_MIN = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic              step_o
);
  logic [DATA_W-1:0] prev_q;
  logic [DATA_W-1:0] diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= data_i;
  end

  // difference only meaningful when data_i > prev_q, so no wrap can qualify
  assign diff   = data_i - prev_q;
  assign step_o = (data_i > prev_q) && (diff >= DATA_W'(STEP_MIN));
endmodule

// File: rtl/zero_run_detect.sv
module zero_run_detect #(
  parameter int unsigned DATA_W   = 3,
  parameter int unsigned RUN_LEN  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic              clr_o
);
  localparam int unsigned RUN_W = $clog2(RUN_LEN + 1);

  logic [RUN_W-1:0] run_q, run_d;
  logic             is_zero;

  assign is_zero = (data_i == '0);

  always_comb begin
    if (!is_zero)                       run_d = '0;
    else if (run_q == RUN_W'(RUN_LEN))  run_d = run_q;
    else                                run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= run_d;
  end

  // current zero completes (or extends) a full run
  assign clr_o = is_zero && (run_q >= RUN_W'(RUN_LEN - 1));
endmodule

// File: rtl/sat_event_counter.sv
module sat_event_counter #(
  parameter int unsigned CNT_W   = 3,
  parameter int unsigned CNT_MAX = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o,
  output logic             alarm_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CNT_MAX);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             alm_q, alm_d;
  logic             bump;

  assign bump = inc_i && (cnt_q != LIMIT);

  always_comb begin
    cnt_d = cnt_q;
    alm_d = alm_q;
    if (clr_i) begin
      cnt_d = '0;
      alm_d = 1'b0;
    end else if (bump) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LIMIT - 1'b1) alm_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      alm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      alm_q <= alm_d;
    end
  end

  assign count_o = cnt_q;
  assign alarm_o = alm_q;
endmodule

// File: rtl/step_event_counter.sv
module step_event_counter
  import step_event_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              alarm_o
);
  logic step, clr;

  step_detect #(.DATA_W(DATA_W), .STEP_MIN(STEP_MIN)) u_step (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .data_i(data_i),
    .step_o(step)
  );

  zero_run_detect #(.DATA_W(DATA_W), .RUN_LEN(ZERO_RUN)) u_zero (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .data_i(data_i),
    .clr_o (clr)
  );

  sat_event_counter #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (step),
    .count_o(count_o),
    .alarm_o(alarm_o)
  );
endmodule

// File: rtl/step_event_counter_chk.sv
module step_event_counter_chk
  import step_event_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] data_i,
  input logic [CNT_W-1:0]  count_o,
  input logic              alarm_o
);
  logic [1:0] since_rst;
  int unsigned zeros_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst  <= '0;
      zeros_seen <= 0;
    end else begin
      if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
      if (data_i != '0)               zeros_seen <= 0;
      else if (zeros_seen < ZERO_RUN) zeros_seen <= zeros_seen + 1;
    end
  end

  // R6
  alarm_tracks_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o == (int'(count_o) == int'(CNT_MAX)));

  // R5
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_o) <= int'(CNT_MAX));

  // R2
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst != 2'd0 && count_o != $past(count_o)) |->
      (count_o == '0 || int'(count_o) == int'($past(count_o)) + 1));

  // R3
  jump_needed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd2 && int'(count_o) == int'($past(count_o)) + 1) |->
      (int'($past(data_i)) >= int'($past(data_i, 2)) + int'(STEP_MIN)));

  // R5
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(count_o) == int'(CNT_MAX) && data_i != '0) |=> int'(count_o) == int'(CNT_MAX));

  // R7
  zero_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_i == '0 && zeros_seen + 1 >= ZERO_RUN) |=> (count_o == '0 && !alarm_o));
endmodule

bind step_event_counter step_event_counter_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .data_i (data_i),
  .count_o(count_o),
  .alarm_o(alarm_o)
);

// File: tb/tb_step_event_counter.sv
module tb_step_event_counter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] data_i = '0;
  logic [2:0] count_o;
  logic       alarm_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int hist[$];
  int m_prev = 0;
  int m_cnt  = 0;
  bit m_alm  = 0;

  step_event_counter dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .count_o(count_o),
    .alarm_o(alarm_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic model_reset();
    hist.delete();
    m_prev = 0;
    m_cnt  = 0;
    m_alm  = 0;
  endtask

  task automatic model_step(input int d);
    bit clear;
    hist.push_back(d);
    if (hist.size() > 3) void'(hist.pop_front());
    clear = (hist.size() == 3) && (hist[0] == 0) && (hist[1] == 0) && (hist[2] == 0);
    if (clear) begin
      m_cnt = 0;
      m_alm = 0;
    end else if (d - m_prev >= 2 && m_cnt < 6) begin
      m_cnt = m_cnt + 1;
      if (m_cnt == 6) m_alm = 1;
    end
    m_prev = d;
  endtask

  task automatic check(input string req);
    checks++;
    if (int'(count_o) !== m_cnt || alarm_o !== m_alm) begin
      fails++;
      $display("FAIL %s: count=%0d alarm=%0b expected count=%0d alarm=%0b at %0t",
               req, count_o, alarm_o, m_cnt, m_alm, $time);
    end
  endtask

  // called at a negedge: drive, pass one rising edge, compare at next negedge
  task automatic step(input int d, input string req);
    data_i = 3'(d);
    @(posedge clk_i);
    model_step(d);
    @(negedge clk_i);
    check(req);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    data_i = 3'd5;
    repeat (3) @(negedge clk_i);
    check("R1");                 // outputs low while reset held
    rst_ni = 1'b1;

    // R1: first sample compared against 0; R2 jump from 0 to 2
    step(2, "R1");
    // R3: +1, equal, decrease do not count
    step(3, "R3");
    step(3, "R3");
    step(1, "R3");
    // R4: prev updated on non-counting edges: 1,2,4
    step(2, "R4");
    step(4, "R4");
    step(7, "R2");
    step(5, "R3");
    step(7, "R2");
    // count now 4; climb to 6 with 1,3 pairs
    for (int i = 0; i < 2; i++) begin
      step(1, "R6");
      step(3, "R6");
    end
    // R5: further jumps leave it at 6
    for (int i = 0; i < 3; i++) begin
      step(1, "R5");
      step(4, "R5");
    end
    // R7: two zeros then a large value do not clear
    step(0, "R7");
    step(0, "R7");
    step(6, "R7");
    step(0, "R7");
    step(0, "R7");
    step(0, "R7");               // third zero clears
    step(0, "R8");
    step(0, "R8");
    step(2, "R8");               // 0 -> 2 counts once
    step(3, "R3");

    // async reset mid-run
    step(6, "R2");
    data_i = 3'd7;
    rst_ni = 1'b0;
    model_reset();
    #1;
    check("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1, "R1");
    step(3, "R2");

    // random mix, biased towards zero
    for (int i = 0; i < 2000; i++) begin
      int v;
      v = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(0, 7));
      step(v, "R7");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule